// File: doc/BRIEF.md
# Piecewise Polynomial Angle Compensator

This block removes the systematic error that unequal receiver channel gains leave in a measured arrival angle. The angular range is cut into thirteen domains. The domain that applies to a sample is named by the integer step index that an upstream dual-baseline ambiguity resolver produces. Each domain has its own fifth-order error polynomial. The block evaluates that polynomial at the measured angle and subtracts the result from the angle.

The evaluation uses Horner's rule on a single multiply-add datapath. One sample is accepted and then occupies the datapath for five further clock edges. The twenty-bit coefficients sit in a small register file, and a simple write port loads it while the block is idle. A step index outside the thirteen domains skips the correction, and the angle comes out on the next cycle. A fitting process elsewhere computes the coefficients.

Top module: `angle_poly_comp`

## Requirements
- R1: After reset `out_valid` is low and every coefficient is zero, so an evaluated sample returns its own angle unchanged.
- R2: Angles and coefficients are 20-bit two's complement with 11 fraction bits (range -256.0 to +255.99951 degrees, step 2^-11).
- R3: For domain d the error is e = ((((c5*x + c4)*x + c3)*x + c2)*x + c1)*x + c0, where ck is the coefficient of x^k. Each product is rounded half-up to 11 fraction bits (add 2^-12, then floor) and clamped to the 20-bit range. Each sum is also clamped.
- R4: The compensated output is x - e, clamped to the 20-bit range.
- R5: A sample with a step index of 0..12 is taken at the clock edge where `in_valid` is high and the block is idle. `out_valid` is high for exactly one cycle, following the fifth rising edge after the accepting edge, and stays low before that.
- R6: A sample with a step index of 13..15 is output unchanged, with `out_valid` high, in the cycle after the accepting edge.
- R7: `in_valid` pulses that arrive while an evaluation is running are dropped. They change neither the running result nor the later outputs.
- R8: A coefficient write sets entry {domain = `cfg_addr[6:3]`, power = `cfg_addr[2:0]`} at the edge where `cfg_we` is high. An address with domain above 12 or power above 5 changes nothing.
- R9: A coefficient write during an evaluation changes no coefficient.
- R10: Each domain uses only its own six coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_angle | input | 20 | Measured angle, 9.11 signed |
| in_domain | input | 4 | Domain step index |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 7 | {domain, power} write address |
| cfg_data | input | 20 | Coefficient value, 9.11 signed |
| out_valid | output | 1 | Result strobe |
| out_angle | output | 20 | Compensated angle, 9.11 signed |

## Verification
Some properties are checked on every cycle: bypass pass-through, silence on `out_valid` during a running evaluation, a result on the final Horner step, a frozen operand while the evaluation runs, a frozen coefficient file when writes are locked or misaddressed, and adders that never wrap sign. Other behaviour can only be shown by the bench scenarios. These are the numeric value of each result against an independent Horner model across random domains, angles and coefficients, forced saturation of a product and of the final subtraction, dropped samples and writes in the middle of an evaluation, and the per-domain selection.

// File: rtl/acomp_pkg.sv
package acomp_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EVAL = 1'b1
    } acomp_phase_e;

    function automatic int sel_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/acomp_sat_sum.sv
module acomp_sat_sum #(
    parameter int W   = 20,
    parameter bit SUB = 1'b0
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    logic signed [W:0] ea;
    logic signed [W:0] eb;
    logic signed [W:0] s;

    assign ea = {a_i[W-1], a_i};
    assign eb = {b_i[W-1], b_i};

    generate
        if (SUB) begin : g_sub
            assign s = ea - eb;
            // R4: nonnegative minus negative never yields a negative difference
            always_comb begin
                if (!a_i[W-1] && b_i[W-1]) begin
                    a_r4_sub_no_wrap : assert (!y_o[W-1]);
                end
            end
        end else begin : g_add
            assign s = ea + eb;
            // R3: two nonnegative terms never yield a negative sum
            always_comb begin
                if (!a_i[W-1] && !b_i[W-1]) begin
                    a_r3_add_no_wrap : assert (!y_o[W-1]);
                end
            end
        end
    endgenerate

    always_comb begin
        if (s[W] != s[W-1]) begin
            y_o = s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            y_o = s[W-1:0];
        end
    end
endmodule

// File: rtl/acomp_horner_step.sv
module acomp_horner_step #(
    parameter int W = 20,
    parameter int F = 11
) (
    input  logic signed [W-1:0] acc_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] coef_i,
    output logic signed [W-1:0] res_o
);
    localparam int PW = 2 * W + 1;
    localparam logic signed [PW-1:0] HI   = PW'((64'sd1 <<< (W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] LO   = -HI - PW'(1);
    localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (F - 1));

    logic signed [2*W-1:0] prod;
    logic signed [PW-1:0]  rnd;
    logic signed [PW-1:0]  shf;
    logic signed [W-1:0]   prod_r;

    always_comb begin
        prod = acc_i * x_i;
        rnd  = PW'(prod) + HALF;
        shf  = rnd >>> F;
        if (shf > HI) begin
            prod_r = HI[W-1:0];
        end else if (shf < LO) begin
            prod_r = LO[W-1:0];
        end else begin
            prod_r = shf[W-1:0];
        end
    end

    acomp_sat_sum #(.W(W), .SUB(1'b0)) u_add (
        .a_i(prod_r),
        .b_i(coef_i),
        .y_o(res_o)
    );
endmodule

// File: rtl/acomp_coef_bank.sv
module acomp_coef_bank #(
    parameter int NDOM  = 13,
    parameter int NCOEF = 6,
    parameter int W     = 20,
    parameter int DW    = 4,
    parameter int CW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_i,
    input  logic                 we_i,
    input  logic [DW+CW-1:0]     waddr_i,
    input  logic signed [W-1:0]  wdata_i,
    input  logic [DW-1:0]        rdom_i,
    input  logic [CW-1:0]        ridx_i,
    output logic signed [W-1:0]  rdata_o
);
    localparam int N  = NDOM * NCOEF;
    localparam int SW = acomp_pkg::sel_bits(N);

    logic [N-1:0][W-1:0] mem_d;
    logic [N-1:0][W-1:0] mem_q;
    logic [DW-1:0] wdom;
    logic [CW-1:0] widx;
    logic          w_in_map;
    logic          r_in_map;
    logic [SW-1:0] wslot;
    logic [SW-1:0] rslot;

    assign wdom     = waddr_i[DW+CW-1:CW];
    assign widx     = waddr_i[CW-1:0];
    assign w_in_map = (int'(wdom) < NDOM) && (int'(widx) < NCOEF);
    assign r_in_map = (int'(rdom_i) < NDOM) && (int'(ridx_i) < NCOEF);
    assign wslot    = SW'(int'(wdom) * NCOEF + int'(widx));
    assign rslot    = SW'(int'(rdom_i) * NCOEF + int'(ridx_i));

    always_comb begin
        mem_d = mem_q;
        if (we_i && !lock_i && w_in_map) begin
            mem_d[wslot] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = r_in_map ? $signed(mem_q[rslot]) : '0;

    // R9: a locked file holds every coefficient across the edge
    a_r9_locked_hold : assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(mem_q));

    // R8: an address outside the map changes nothing
    a_r8_bad_addr_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !w_in_map) |=> $stable(mem_q));
endmodule

// File: rtl/angle_poly_comp.sv
module angle_poly_comp #(
    parameter int NDOM  = 13,
    parameter int NCOEF = 6,
    parameter int W     = 20,
    parameter int F     = 11,
    localparam int DW   = acomp_pkg::sel_bits(NDOM + 1),
    localparam int CW   = acomp_pkg::sel_bits(NCOEF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_angle,
    input  logic [DW-1:0]        in_domain,
    input  logic                 cfg_we,
    input  logic [DW+CW-1:0]     cfg_addr,
    input  logic signed [W-1:0]  cfg_data,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_angle
);
    import acomp_pkg::*;

    typedef struct packed {
        acomp_phase_e       phase;
        logic [DW-1:0]      dom;
        logic [CW-1:0]      k;
        logic signed [W-1:0] x;
        logic signed [W-1:0] acc;
        logic               vld;
        logic signed [W-1:0] y;
    } ctl_t;

    ctl_t st_d;
    ctl_t st_q;

    logic               evaluating;
    logic [DW-1:0]      rd_dom;
    logic [CW-1:0]      rd_idx;
    logic signed [W-1:0] coef;
    logic signed [W-1:0] step_res;
    logic signed [W-1:0] diff;
    logic               bypass_req;

    assign evaluating = (st_q.phase == PH_EVAL);
    assign rd_dom     = evaluating ? st_q.dom : in_domain;
    assign rd_idx     = evaluating ? st_q.k : CW'(NCOEF - 1);
    assign bypass_req = (int'(in_domain) >= NDOM);

    acomp_coef_bank #(
        .NDOM(NDOM), .NCOEF(NCOEF), .W(W), .DW(DW), .CW(CW)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (evaluating),
        .we_i   (cfg_we),
        .waddr_i(cfg_addr),
        .wdata_i(cfg_data),
        .rdom_i (rd_dom),
        .ridx_i (rd_idx),
        .rdata_o(coef)
    );

    acomp_horner_step #(.W(W), .F(F)) u_step (
        .acc_i (st_q.acc),
        .x_i   (st_q.x),
        .coef_i(coef),
        .res_o (step_res)
    );

    acomp_sat_sum #(.W(W), .SUB(1'b1)) u_final (
        .a_i(st_q.x),
        .b_i(step_res),
        .y_o(diff)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    if (bypass_req) begin
                        st_d.vld = 1'b1;
                        st_d.y   = in_angle;
                    end else begin
                        st_d.phase = PH_EVAL;
                        st_d.dom   = in_domain;
                        st_d.x     = in_angle;
                        st_d.acc   = coef;
                        st_d.k     = CW'(NCOEF - 2);
                    end
                end
            end
            PH_EVAL: begin
                st_d.acc = step_res;
                if (st_q.k == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.vld   = 1'b1;
                    st_d.y     = diff;
                end else begin
                    st_d.k = st_q.k - CW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_angle = st_q.y;

    // R6: out-of-range step index passes the angle straight through
    a_r6_bypass_pass : assert property (@(posedge clk) disable iff (!rst_n)
        (!evaluating && in_valid && bypass_req) |=> (out_valid && out_angle == $past(in_angle)));

    // R5: no result strobe while the polynomial is still running
    a_r5_quiet_eval : assert property (@(posedge clk) disable iff (!rst_n)
        evaluating |-> !out_valid);

    // R5: the last Horner step produces the result and frees the datapath
    a_r5_result_on_last : assert property (@(posedge clk) disable iff (!rst_n)
        (evaluating && st_q.k == '0) |=> (out_valid && !evaluating));

    // R7: the operand and domain stay frozen during an evaluation
    a_r7_operand_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (evaluating && st_q.k != '0) |=> ($stable(st_q.x) && $stable(st_q.dom)));
endmodule

// File: tb/tb_angle_poly_comp.sv
module tb_angle_poly_comp;
    localparam int W = 20;
    localparam int F = 11;
    localparam int NDOM = 13;
    localparam int NCOEF = 6;
    localparam longint MAXV = (64'sd1 <<< (W - 1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_angle = '0;
    logic [3:0] in_domain = '0;
    logic cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic signed [W-1:0] cfg_data = '0;
    logic out_valid;
    logic signed [W-1:0] out_angle;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint cm [NDOM][NCOEF];

    always #2.5ns clk = ~clk;

    angle_poly_comp dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
        .in_domain(in_domain), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .out_valid(out_valid), .out_angle(out_angle)
    );

    function automatic longint clampv(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic longint model(input int d, input longint x);
        longint acc;
        if (d >= NDOM) return x;
        acc = cm[d][NCOEF-1];
        for (int k = NCOEF - 2; k >= 0; k--) begin
            acc = clampv((acc * x + (64'sd1 <<< (F - 1))) >>> F);
            acc = clampv(acc + cm[d][k]);
        end
        return clampv(x - acc);
    endfunction

    function automatic longint rrange(input longint lo, input longint hi);
        return lo + longint'($urandom % 32'(hi - lo + 1));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int d, input int k, input longint v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 7'((d << 3) | k);
        cfg_data = W'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        if (d < NDOM && k < NCOEF) cm[d][k] = v;
    endtask

    // inject: 0 none, 1 extra sample mid-run (R7), 2 coefficient write mid-run (R9)
    task automatic run(input string req, input int d, input longint x, input int inject);
        longint exp;
        int early;
        exp = model(d, x);
        @(negedge clk);
        in_valid = 1'b1;
        in_domain = 4'(d);
        in_angle = W'(x);
        @(negedge clk);
        in_valid = 1'b0;
        if (d >= NDOM) begin
            chk({req, " bypass valid"}, longint'(out_valid), 1);
            chk({req, " bypass value"}, longint'($signed(out_angle)), exp);
        end else begin
            early = 0;
            for (int i = 0; i < 5; i++) begin
                if (i > 0) @(negedge clk);
                if (out_valid) early++;
                if (i == 2 && inject == 1) begin
                    in_valid = 1'b1;
                    in_domain = 4'((d + 1) % NDOM);
                    in_angle = W'(x ^ 64'h155);
                end
                if (i == 2 && inject == 2) begin
                    cfg_we = 1'b1;
                    cfg_addr = 7'(d << 3);
                    cfg_data = W'(cm[d][0] + 777);
                end
                if (i == 3) begin
                    in_valid = 1'b0;
                    cfg_we = 1'b0;
                end
            end
            chk({req, " R5 no early strobe"}, early, 0);
            @(negedge clk);
            chk({req, " R5 strobe at step six"}, longint'(out_valid), 1);
            chk({req, " value"}, longint'($signed(out_angle)), exp);
            @(negedge clk);
            chk({req, " R5 single strobe"}, longint'(out_valid), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int d = 0; d < NDOM; d++)
            for (int k = 0; k < NCOEF; k++) cm[d][k] = 0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid low in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid low after reset", longint'(out_valid), 0);
        run("R1 zero coefficients", 4, 12345, 0);
        run("R2 negative angle identity", 9, -200000, 0);
        run("R6 bypass index 13", 13, -4321, 0);
        run("R6 bypass index 15", 15, MAXV, 0);

        // R8 legal writes, then R10 per-domain selection
        wr(3, 0, 2048);
        wr(3, 1, 1024);
        run("R8 R10 domain 3 programmed", 3, 4096, 0);
        run("R10 domain 4 untouched", 4, 4096, 0);

        // R8 unmapped addresses: domain 13 and powers 6, 7
        wr(13, 0, 99999);
        wr(0, 6, 99999);
        wr(0, 7, 99999);
        run("R8 unmapped writes ignored", 0, 30000, 0);

        // random coefficients in every domain
        for (int d = 0; d < NDOM; d++)
            for (int k = 0; k < NCOEF; k++)
                wr(d, k, (k == 0) ? rrange(-8192, 8192) : rrange(-2048, 2048));

        // R3 product saturation, R4 final-difference saturation
        wr(1, 5, MAXV);
        for (int k = 0; k < 5; k++) wr(1, k, 0);
        run("R3 product saturation", 1, MAXV, 0);
        run("R3 negative saturation", 1, MINV, 0);
        wr(2, 0, MAXV);
        for (int k = 1; k < NCOEF; k++) wr(2, k, 0);
        run("R4 difference clamps low", 2, -409600, 0);

        run("R7 mid-run sample dropped", 5, 7000, 1);
        run("R9 mid-run write dropped", 6, -9000, 2);
        run("R9 coefficient kept", 6, -9000, 0);

        for (int t = 0; t < 150; t++) begin
            int d;
            longint x;
            d = int'($urandom % 16);
            x = (t % 5 == 0) ? rrange(MINV, MAXV) : rrange(-32768, 32768);
            run("R3 R4 random", d, x, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule